// File: doc/BRIEF.md
# Board Platform Status Registers

This block is a 4 KiB window of control and status words for a development board. A bus master reads it to learn how the board was built and configured. The words cover the build identity, the clock generator settings, the DRAM state, the PCIe lane state and the installed memory size. Most of these words are fixed. Two of them carry live values that the block takes from its inputs: the timer input frequency in MHz and the RAM size in GiB. Three more live inputs supply the PCIe lock flags.

The block honours only full 32-bit accesses. A full-word write to the soft reset control word, with the request bit set, produces a one-cycle system reset request. The system uses that request to restart the board. The block's own state is cleared only by its external reset.

Top module: `plat_status_regs`

## Requirements
- R1: After reset, `bus_rdata_o` is zero and `sys_rst_req_o` is low.
- R2: A full-word read of offset 0x000 (build identity), 0x004 (core change number) or 0x008 (wrapper change number) returns zero.
- R3: A full-word read of offset 0x014 (DRAM state) returns 0x00000005: bit 0 is locked and bit 2 is calibrated.
- R4: A full-word read of offset 0x018 (PCIe state) returns `pcie_lock_i[0]` in bit 0, `pcie_lock_i[1]` in bit 8 and `pcie_lock_i[2]` in bit 16. All other bits are zero.
- R5: A full-word read of offset 0x030 (clock generator) returns 1 in bits 31:24, 1 in bits 23:16, `timer_mhz_i` in bits 15:8 and 1 in bits 7:0.
- R6: A full-word read of offset 0x034 (build options) returns 0x0000000E: bits 1 to 3 are set for the three PCIe ports, and bit 0 (coherence unit) is clear.
- R7: A full-word read of offset 0x038 (DRAM options) returns `ram_gib_i` in bits 3:0 and ones in bits 15:4. Bits 31:16 are zero.
- R8: `bus_size_i` selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A read of any size other than 4 bytes returns zero.
- R9: A read of any other offset returns zero. This includes the soft reset control word at 0x010 and any offset that is not word aligned.
- R10: A full-word write to offset 0x010 with bit 4 of the data set drives `sys_rst_req_o` high for exactly the following cycle.
- R11: No other write raises `sys_rst_req_o` or changes any later read value. This covers writes with bit 4 clear, writes of any other size, and writes to any other offset.
- R12: Read data is registered. It changes on the clock edge that samples a read and holds through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; the low 12 bits select the word |
| bus_size_i | input | 2 | Access size code (0=1B, 1=2B, 2=4B, 3=8B) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| timer_mhz_i | input | 8 | Timer input frequency in MHz |
| ram_gib_i | input | 4 | Installed RAM in GiB |
| pcie_lock_i | input | N_PCIE | Per-lane PCIe lock flags |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A decode fault shows on the read port in the cycle right after the read strobe, as a wrong word for the offset that was read. A wrong size check shows the same way. A reset request with no cause, or a missing one, shows on `sys_rst_req_o` one cycle after the write. A request that stays high shows in the cycle after that.

Read data that does not hold is caught on the first idle or write cycle that follows a read. The bench mixes random offsets, sizes and live input values with directed accesses, so a stale or misplaced live field shows up the first time its input changes.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

  localparam int unsigned PLAT_DW        = 32;
  localparam int unsigned PLAT_WIN_W     = 12;
  localparam int unsigned PLAT_MHZ_W     = 8;
  localparam int unsigned PLAT_GIB_W     = 4;
  localparam int unsigned PLAT_LANE_STEP = 8;
  localparam int unsigned PLAT_RST_BIT   = 4;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam logic [PLAT_WIN_W-1:0] OFF_BUILD   = 12'h000;
  localparam logic [PLAT_WIN_W-1:0] OFF_CORE_CN = 12'h004;
  localparam logic [PLAT_WIN_W-1:0] OFF_WRAP_CN = 12'h008;
  localparam logic [PLAT_WIN_W-1:0] OFF_SOFTRST = 12'h010;
  localparam logic [PLAT_WIN_W-1:0] OFF_DRAM_ST = 12'h014;
  localparam logic [PLAT_WIN_W-1:0] OFF_PCIE_ST = 12'h018;
  localparam logic [PLAT_WIN_W-1:0] OFF_CLKGEN  = 12'h030;
  localparam logic [PLAT_WIN_W-1:0] OFF_BLDOPT  = 12'h034;
  localparam logic [PLAT_WIN_W-1:0] OFF_DRAMOPT = 12'h038;

  localparam logic [PLAT_DW-1:0] DRAM_ST_WORD = 32'h0000_0005;
  localparam logic [PLAT_DW-1:0] BLDOPT_WORD  = 32'h0000_000E;
  localparam logic [7:0]         CLK_UNITY    = 8'd1;
  localparam logic [11:0]        DRAM_MHZ_ALL = 12'hFFF;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_BUILD,
    REG_CORE_CN,
    REG_WRAP_CN,
    REG_SOFTRST,
    REG_DRAM_ST,
    REG_PCIE_ST,
    REG_CLKGEN,
    REG_BLDOPT,
    REG_DRAMOPT
  } plat_reg_e;

endpackage

// File: rtl/plat_rst_sync.sv
module plat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/plat_reg_decode.sv
module plat_reg_decode
  import plat_regs_pkg::*;
(
  input  logic [PLAT_WIN_W-1:0] offset_i,
  output plat_reg_e             reg_o
);
  always_comb begin
    unique case (offset_i)
      OFF_BUILD:   reg_o = REG_BUILD;
      OFF_CORE_CN: reg_o = REG_CORE_CN;
      OFF_WRAP_CN: reg_o = REG_WRAP_CN;
      OFF_SOFTRST: reg_o = REG_SOFTRST;
      OFF_DRAM_ST: reg_o = REG_DRAM_ST;
      OFF_PCIE_ST: reg_o = REG_PCIE_ST;
      OFF_CLKGEN:  reg_o = REG_CLKGEN;
      OFF_BLDOPT:  reg_o = REG_BLDOPT;
      OFF_DRAMOPT: reg_o = REG_DRAMOPT;
      default:     reg_o = REG_NONE;
    endcase
  end
endmodule

// File: rtl/plat_read_mux.sv
module plat_read_mux
  import plat_regs_pkg::*;
#(
  parameter int unsigned N_PCIE = 3
) (
  input  plat_reg_e               reg_i,
  input  logic [PLAT_MHZ_W-1:0]   timer_mhz_i,
  input  logic [PLAT_GIB_W-1:0]   ram_gib_i,
  input  logic [N_PCIE-1:0]       pcie_lock_i,
  output logic [PLAT_DW-1:0]      word_o
);
  localparam int unsigned DRAMOPT_PAD = PLAT_DW - 12 - PLAT_GIB_W;

  logic [PLAT_DW-1:0] pcie_word;
  logic [PLAT_DW-1:0] clk_word;
  logic [PLAT_DW-1:0] dramopt_word;

  always_comb begin
    pcie_word = '0;
    for (int i = 0; i < int'(N_PCIE); i++) begin
      pcie_word[i*PLAT_LANE_STEP] = pcie_lock_i[i];
    end
  end

  assign clk_word     = {CLK_UNITY, CLK_UNITY, timer_mhz_i, CLK_UNITY};
  assign dramopt_word = {{DRAMOPT_PAD{1'b0}}, DRAM_MHZ_ALL, ram_gib_i};

  always_comb begin
    unique case (reg_i)
      REG_DRAM_ST: word_o = DRAM_ST_WORD;
      REG_PCIE_ST: word_o = pcie_word;
      REG_CLKGEN:  word_o = clk_word;
      REG_BLDOPT:  word_o = BLDOPT_WORD;
      REG_DRAMOPT: word_o = dramopt_word;
      default:     word_o = '0;
    endcase
  end
endmodule

// File: rtl/plat_softrst.sv
module plat_softrst
  import plat_regs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_fire_i,
  input  logic               is_ctl_i,
  input  logic [PLAT_DW-1:0] wdata_i,
  output logic               req_o
);
  logic req_d;
  logic req_q;

  always_comb begin
    req_d = wr_fire_i & is_ctl_i & wdata_i[PLAT_RST_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/plat_status_regs.sv
module plat_status_regs
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_PCIE = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_sel_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [1:0]            bus_size_i,
  input  logic [PLAT_DW-1:0]    bus_wdata_i,
  output logic [PLAT_DW-1:0]    bus_rdata_o,
  input  logic [PLAT_MHZ_W-1:0] timer_mhz_i,
  input  logic [PLAT_GIB_W-1:0] ram_gib_i,
  input  logic [N_PCIE-1:0]     pcie_lock_i,
  output logic                  sys_rst_req_o
);
  logic               rst_n;
  plat_reg_e          reg_sel;
  logic               word_ok;
  logic               rd_fire;
  logic               wr_fire;
  logic [PLAT_DW-1:0] rd_word;
  logic [PLAT_DW-1:0] rdata_d;
  logic [PLAT_DW-1:0] rdata_q;

  plat_rst_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  plat_reg_decode u_dec (
    .offset_i(bus_addr_i[PLAT_WIN_W-1:0]),
    .reg_o   (reg_sel)
  );

  plat_read_mux #(.N_PCIE(N_PCIE)) u_rd (
    .reg_i      (reg_sel),
    .timer_mhz_i(timer_mhz_i),
    .ram_gib_i  (ram_gib_i),
    .pcie_lock_i(pcie_lock_i),
    .word_o     (rd_word)
  );

  assign word_ok = (bus_size_i == SIZE_WORD);
  assign rd_fire = bus_sel_i & ~bus_we_i;
  assign wr_fire = bus_sel_i & bus_we_i & word_ok;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_fire) rdata_d = word_ok ? rd_word : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  plat_softrst u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_fire_i(wr_fire),
    .is_ctl_i (reg_sel == REG_SOFTRST),
    .wdata_i  (bus_wdata_i),
    .req_o    (sys_rst_req_o)
  );

  // R10: qualifying write yields a request next cycle
  assert_rst_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_size_i == 2'd2 &&
     bus_addr_i[11:0] == 12'h010 && bus_wdata_i[4]) |=> sys_rst_req_o);

  // R11: a request always traces back to a qualifying write
  assert_no_spurious_req_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_req_o |-> ($past(bus_sel_i) && $past(bus_we_i) && $past(bus_size_i) == 2'd2 &&
                       $past(bus_addr_i[11:0]) == 12'h010 && $past(bus_wdata_i[4])));

  // R8: short reads return zero
  assert_short_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_sel_i && !bus_we_i && bus_size_i != 2'd2) |=> (bus_rdata_o == '0));

  // R12: read data holds without a read
  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(bus_sel_i && !bus_we_i) |=> $stable(bus_rdata_o));

  // R3: DRAM state word
  assert_dram_state_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_sel_i && !bus_we_i && bus_size_i == 2'd2 && bus_addr_i[11:0] == 12'h014)
      |=> (bus_rdata_o == 32'h0000_0005));

  // R6: build option word
  assert_build_opts_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_sel_i && !bus_we_i && bus_size_i == 2'd2 && bus_addr_i[11:0] == 12'h034)
      |=> (bus_rdata_o == 32'h0000_000E));
endmodule

// File: tb/tb_plat_status_regs.sv
module tb_plat_status_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  mhz = 8'd25;
  logic [3:0]  gib = 4'd1;
  logic [2:0]  lock = 3'b000;
  logic        rreq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model_rd = '0;

  always #2 clk = ~clk;

  plat_status_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_size_i(size), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .timer_mhz_i(mhz), .ram_gib_i(gib),
    .pcie_lock_i(lock), .sys_rst_req_o(rreq)
  );

  function automatic logic [31:0] exp_word(logic [11:0] a, logic [1:0] sz,
                                           logic [7:0] m, logic [3:0] g, logic [2:0] l);
    if (sz != 2'd2) return 32'h0;
    case (a)
      12'h014: return 32'h0000_0005;
      12'h018: return {15'b0, l[2], 7'b0, l[1], 7'b0, l[0]};
      12'h030: return {8'd1, 8'd1, m, 8'd1};
      12'h034: return 32'h0000_000E;
      12'h038: return {16'h0, 12'hFFF, g};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_req(logic [11:0] a, logic [1:0] sz, logic [31:0] d);
    return (a == 12'h010) && (sz == 2'd2) && d[4];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(string req, logic [11:0] a, logic [1:0] sz);
    sel = 1'b1; we = 1'b0; addr = a; size = sz;
    model_rd = exp_word(a, sz, mhz, gib, lock);
    @(negedge clk);
    sel = 1'b0;
    chk(req, rdata, model_rd);
    chk({req, "/R11 no request on read"}, {31'b0, rreq}, 32'h0);
  endtask

  task automatic do_write(string req, logic [11:0] a, logic [1:0] sz, logic [31:0] d);
    bit e;
    e = exp_req(a, sz, d);
    sel = 1'b1; we = 1'b1; addr = a; size = sz; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    chk(e ? "R10 request pulse" : "R11 no request", {31'b0, rreq}, {31'b0, e});
    chk("R12 rdata held over write", rdata, model_rd);
    if (e) begin
      @(negedge clk);
      chk("R10 pulse one cycle", {31'b0, rreq}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] offs [10];
    void'($urandom(32'd4242));
    offs = '{12'h000, 12'h004, 12'h008, 12'h010, 12'h014,
             12'h018, 12'h030, 12'h034, 12'h038, 12'h03C};
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 request after reset", {31'b0, rreq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after release", rdata, 32'h0);

    do_read("R2 build id", 12'h000, 2'd2);
    do_read("R2 core change", 12'h004, 2'd2);
    do_read("R2 wrapper change", 12'h008, 2'd2);
    do_read("R3 dram state", 12'h014, 2'd2);
    lock = 3'b101;
    do_read("R4 pcie state", 12'h018, 2'd2);
    lock = 3'b010;
    do_read("R4 pcie state lane1", 12'h018, 2'd2);
    mhz = 8'd200;
    do_read("R5 clock gen", 12'h030, 2'd2);
    do_read("R6 build opts", 12'h034, 2'd2);
    gib = 4'd2;
    do_read("R7 dram opts", 12'h038, 2'd2);
    do_read("R8 byte read", 12'h014, 2'd0);
    do_read("R3 dram state again", 12'h014, 2'd2);
    do_read("R8 dword read", 12'h034, 2'd3);
    do_read("R9 softrst read", 12'h010, 2'd2);
    do_read("R6 build opts again", 12'h034, 2'd2);
    do_read("R9 misaligned", 12'h015, 2'd2);
    do_read("R9 unlisted", 12'hFFC, 2'd2);

    do_write("R10", 12'h010, 2'd2, 32'h0000_0010);
    do_write("R11", 12'h010, 2'd2, 32'hFFFF_FFEF);
    do_write("R11", 12'h010, 2'd1, 32'h0000_0010);
    do_write("R11", 12'h014, 2'd2, 32'hFFFF_FFFF);
    do_write("R11", 12'h011, 2'd2, 32'h0000_0010);
    do_read("R11 dram state unchanged", 12'h014, 2'd2);
    do_read("R11 dram opts unchanged", 12'h038, 2'd2);
    @(negedge clk);
    chk("R12 rdata held idle", rdata, model_rd);

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [1:0]  sz;
      mhz  = 8'($urandom);
      gib  = 4'($urandom);
      lock = 3'($urandom);
      a  = ($urandom_range(0, 3) == 0) ? 12'($urandom) : offs[$urandom_range(0, 9)];
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd2;
      if ($urandom_range(0, 2) == 0) do_write("R10/R11 random write", a, sz, 32'($urandom));
      else                          do_read("R2-R9 random read", a, sz);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        chk("R12 random idle hold", rdata, model_rd);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule